// File: doc/BRIEF.md
# SONET Framing-Pattern Aligner

This block sits behind a byte-aligned line receiver and locates the frame boundary in the incoming byte stream. Each byte comes with a byte-rate clock enable. The block watches for a run of `8'hF6` bytes followed at once by an equally long run of `8'h28` bytes. The run length depends on the line rate, chosen by a mode pin: twelve of each at 622 Mbit/s, or three of each at 155 Mbit/s. The block does no bit-level shifting. Byte boundaries are assumed to be correct already.

When a complete pattern is found while searching, a frame-position counter is loaded so that it names the byte after the last `8'h28`. At the next expected frame start the pattern is checked again at the predicted positions. A pass confirms alignment and clears the out-of-frame flag. After that, every frame is checked at the same positions. Four errored frames in a row raise the flag again and restart the search.

Downstream logic uses four outputs:
- the current byte position;
- a strobe on the first framing byte of each frame;
- the out-of-frame flag;
- an 8 kHz reference that is high across the framing bytes and the byte after them, and is held low while out of frame.

Top module: `sonet_frame_aligner`

## Requirements
- R1: After reset `oof` is 1, `frame_start` and `ref_8k` are 0, and `byte_pos` is 0.
- R2: While searching, a run of exactly the mode's run length of `8'hF6` bytes (12 when `mode_hi`=1, 3 when `mode_hi`=0) followed by the same number of `8'h28` bytes loads the position counter. The byte after the last `8'h28` then reads `byte_pos` = 2 × run length.
- R3: A pattern with a short `8'hF6` run, or with a `8'h28` run broken by another byte, does not load the counter. `byte_pos` keeps counting.
- R4: `byte_pos` advances by one on each byte with `byte_en`=1 and holds while `byte_en`=0. Bytes without the enable are not seen by the search.
- R5: Once a pattern has been found, and until the block falls back to searching, `frame_start` is high exactly on enabled bytes at `byte_pos` 0.
- R6: While out of frame, a correct pattern at the expected positions of the next frame clears `oof` at the clock edge that takes the last `8'h28`. A wrong pattern there keeps `oof` high and returns the block to searching, so `frame_start` stops.
- R7: In frame, `oof` rises at the clock edge that takes the last `8'h28` position of the fourth consecutive frame whose pattern is wrong.
- R8: An error-free frame clears the count of errored frames, so three bad frames, one good frame and three bad frames leave `oof` low.
- R9: In frame, `ref_8k` is high for `byte_pos` 0 through 2 × run length (the framing bytes and the byte after them) and low for the rest of the frame.
- R10: `ref_8k` is low whenever `oof` is high.
- R11: The frame length follows the mode: `byte_pos` wraps from `FLEN_HI`−1 to 0 when `mode_hi`=1, and from `FLEN_LO`−1 to 0 when `mode_hi`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_en | input | 1 | Marks a valid byte on `rx_byte` |
| rx_byte | input | 8 | Byte-aligned receive data |
| mode_hi | input | 1 | 1 selects 622 Mbit/s run and frame length, 0 selects 155 Mbit/s |
| oof | output | 1 | Out-of-frame flag |
| frame_start | output | 1 | Strobe on the first framing byte of each frame |
| byte_pos | output | POS_W | Position of the current byte within the frame |
| ref_8k | output | 1 | Reference pulse, once per frame |

## Verification
Two updates can land on the same clock edge: the frame-validity decision on the last `8'h28` position, and the change of `oof` together with the gating of `ref_8k`.

The bench drives whole frames with the final `8'h28` either intact or replaced by `8'h00`. It samples `oof` just after the edge that takes that byte. It then samples `ref_8k` on the byte after the pattern, where the reference is high only if the flag cleared on that same edge.

Confirmation frames, errored-count resets and the fourth-error loss are each judged at that edge.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
  localparam logic [7:0] A1_BYTE = 8'hF6;
  localparam logic [7:0] A2_BYTE = 8'h28;

  typedef enum logic [1:0] {
    ALN_SEARCH  = 2'd0,
    ALN_CONFIRM = 2'd1,
    ALN_SYNC    = 2'd2
  } aln_state_e;
endpackage

// File: rtl/sfa_run_detect.sv
module sfa_run_detect
  import sfa_pkg::*;
#(
  parameter int RUN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_en,
  input  logic [7:0]       rx_byte,
  input  logic [RUN_W-1:0] run_len,
  output logic             hit_o
);
  logic [RUN_W-1:0] a1_run_q, a1_run_d;
  logic [RUN_W-1:0] a2_run_q, a2_run_d;
  logic             is_a1, is_a2, a1_full, a2_last;

  always_comb begin
    is_a1    = (rx_byte == A1_BYTE);
    is_a2    = (rx_byte == A2_BYTE);
    a1_full  = (a1_run_q == run_len);
    a2_last  = ((a2_run_q + RUN_W'(1)) == run_len);
    hit_o    = byte_en && is_a2 && a1_full && a2_last;
    a1_run_d = a1_run_q;
    a2_run_d = a2_run_q;
    if (byte_en) begin
      if (is_a1) begin
        a2_run_d = '0;
        if (a2_run_q != '0) begin
          a1_run_d = RUN_W'(1);
        end else if (!a1_full) begin
          a1_run_d = a1_run_q + RUN_W'(1);
        end
      end else if (is_a2 && a1_full) begin
        if (a2_last) begin
          a1_run_d = '0;
          a2_run_d = '0;
        end else begin
          a2_run_d = a2_run_q + RUN_W'(1);
        end
      end else begin
        a1_run_d = '0;
        a2_run_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a1_run_q <= '0;
      a2_run_q <= '0;
    end else begin
      a1_run_q <= a1_run_d;
      a2_run_q <= a2_run_d;
    end
  end
endmodule

// File: rtl/sfa_frame_pos.sv
module sfa_frame_pos
  import sfa_pkg::*;
#(
  parameter int POS_W = 14,
  parameter int RUN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_en,
  input  logic [7:0]       rx_byte,
  input  logic [RUN_W-1:0] run_len,
  input  logic [POS_W-1:0] last_pos,
  input  logic             load,
  output logic [POS_W-1:0] pos_o,
  output logic [POS_W-1:0] two_run_o,
  output logic             chk_stb_o,
  output logic             chk_ok_o
);
  logic [POS_W-1:0] pos_q, pos_d;
  logic             err_q, err_d;
  logic [POS_W-1:0] run_ext, two_run;
  logic             in_a1, in_win, last_win, mism;
  logic [7:0]       exp_byte;

  always_comb begin
    run_ext   = POS_W'(run_len);
    two_run   = run_ext + run_ext;
    in_a1     = (pos_q < run_ext);
    in_win    = (pos_q < two_run);
    last_win  = (pos_q == (two_run - POS_W'(1)));
    exp_byte  = in_a1 ? A1_BYTE : A2_BYTE;
    mism      = (rx_byte != exp_byte);
    chk_stb_o = byte_en && last_win;
    chk_ok_o  = !(err_q || mism);
    pos_o     = pos_q;
    two_run_o = two_run;

    pos_d = pos_q;
    err_d = err_q;
    if (byte_en) begin
      if (load) begin
        pos_d = two_run;
      end else if (pos_q == last_pos) begin
        pos_d = '0;
      end else begin
        pos_d = pos_q + POS_W'(1);
      end
      if (in_win) begin
        err_d = (pos_q == '0) ? mism : (err_q || mism);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      err_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/sfa_sync_fsm.sv
module sfa_sync_fsm
  import sfa_pkg::*;
#(
  parameter int BAD_LIMIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic       chk_stb,
  input  logic       chk_ok,
  output aln_state_e state_o
);
  localparam int BAD_W = $clog2(BAD_LIMIT + 1);

  aln_state_e       state_q, state_d;
  logic [BAD_W-1:0] bad_q, bad_d;

  always_comb begin
    state_d = state_q;
    bad_d   = bad_q;
    case (state_q)
      ALN_SEARCH: begin
        if (hit) begin
          state_d = ALN_CONFIRM;
          bad_d   = '0;
        end
      end
      ALN_CONFIRM: begin
        if (chk_stb) begin
          state_d = chk_ok ? ALN_SYNC : ALN_SEARCH;
        end
      end
      ALN_SYNC: begin
        if (chk_stb) begin
          if (chk_ok) begin
            bad_d = '0;
          end else if (bad_q == BAD_W'(BAD_LIMIT - 1)) begin
            state_d = ALN_SEARCH;
            bad_d   = '0;
          end else begin
            bad_d = bad_q + BAD_W'(1);
          end
        end
      end
      default: begin
        state_d = ALN_SEARCH;
        bad_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ALN_SEARCH;
      bad_q   <= '0;
    end else begin
      state_q <= state_d;
      bad_q   <= bad_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/sonet_frame_aligner.sv
module sonet_frame_aligner
  import sfa_pkg::*;
#(
  parameter int FLEN_HI   = 9720,
  parameter int FLEN_LO   = 2430,
  parameter int RUN_HI    = 12,
  parameter int RUN_LO    = 3,
  parameter int BAD_LIMIT = 4,
  localparam int FLEN_MAX = (FLEN_HI > FLEN_LO) ? FLEN_HI : FLEN_LO,
  localparam int RUN_MAX  = (RUN_HI > RUN_LO) ? RUN_HI : RUN_LO,
  localparam int POS_W    = $clog2(FLEN_MAX),
  localparam int RUN_W    = $clog2(RUN_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_en,
  input  logic [7:0]       rx_byte,
  input  logic             mode_hi,
  output logic             oof,
  output logic             frame_start,
  output logic [POS_W-1:0] byte_pos,
  output logic             ref_8k
);
  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic [RUN_W-1:0] run_len;
  logic [POS_W-1:0] last_pos;
  logic [POS_W-1:0] pos, two_run;
  logic             hit, load, chk_stb, chk_ok;
  aln_state_e       state;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  always_comb begin
    run_len  = mode_hi ? RUN_W'(RUN_HI) : RUN_W'(RUN_LO);
    last_pos = mode_hi ? POS_W'(FLEN_HI - 1) : POS_W'(FLEN_LO - 1);
    load     = hit && (state == ALN_SEARCH);
  end

  sfa_run_detect #(.RUN_W(RUN_W)) u_detect (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .byte_en (byte_en),
    .rx_byte (rx_byte),
    .run_len (run_len),
    .hit_o   (hit)
  );

  sfa_frame_pos #(.POS_W(POS_W), .RUN_W(RUN_W)) u_pos (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .byte_en   (byte_en),
    .rx_byte   (rx_byte),
    .run_len   (run_len),
    .last_pos  (last_pos),
    .load      (load),
    .pos_o     (pos),
    .two_run_o (two_run),
    .chk_stb_o (chk_stb),
    .chk_ok_o  (chk_ok)
  );

  sfa_sync_fsm #(.BAD_LIMIT(BAD_LIMIT)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .hit     (hit),
    .chk_stb (chk_stb),
    .chk_ok  (chk_ok),
    .state_o (state)
  );

  always_comb begin
    oof         = (state != ALN_SYNC);
    frame_start = byte_en && (pos == '0) && (state != ALN_SEARCH);
    ref_8k      = (state == ALN_SYNC) && (pos <= two_run);
    byte_pos    = pos;
  end
endmodule

// File: rtl/sonet_frame_aligner_chk.sv
module sonet_frame_aligner_chk #(
  parameter int FLEN_HI = 9720,
  parameter int FLEN_LO = 2430,
  parameter int RUN_HI  = 12,
  parameter int RUN_LO  = 3,
  parameter int POS_W   = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_en,
  input logic             mode_hi,
  input logic             oof,
  input logic             frame_start,
  input logic [POS_W-1:0] byte_pos,
  input logic             ref_8k
);
  logic [POS_W-1:0] two_run_c, last_c;

  always_comb begin
    two_run_c = mode_hi ? POS_W'(2 * RUN_HI) : POS_W'(2 * RUN_LO);
    last_c    = mode_hi ? POS_W'(FLEN_HI - 1) : POS_W'(FLEN_LO - 1);
  end

  // R4
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_en |=> $stable(byte_pos));

  // R11
  pos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_en && !oof && byte_pos == last_c) |=> (byte_pos == '0));

  // R5
  start_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (byte_en && byte_pos == '0));

  // R6
  oof_clear_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oof) |-> ($past(byte_en) && $past(byte_pos) == two_run_c - POS_W'(1)));

  // R7
  oof_set_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oof) |-> ($past(byte_en) && $past(byte_pos) == two_run_c - POS_W'(1)));

  // R9
  ref_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_8k |-> (byte_pos <= two_run_c));

  // R10
  ref_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oof |-> !ref_8k);
endmodule

bind sonet_frame_aligner sonet_frame_aligner_chk #(
  .FLEN_HI (FLEN_HI),
  .FLEN_LO (FLEN_LO),
  .RUN_HI  (RUN_HI),
  .RUN_LO  (RUN_LO),
  .POS_W   (POS_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .byte_en     (byte_en),
  .mode_hi     (mode_hi),
  .oof         (oof),
  .frame_start (frame_start),
  .byte_pos    (byte_pos),
  .ref_8k      (ref_8k)
);

// File: tb/tb_sonet_frame_aligner.sv
`timescale 1ns/1ps
module tb_sonet_frame_aligner;
  localparam int FLEN_HI = 60;
  localparam int FLEN_LO = 30;
  localparam int RUN_HI  = 12;
  localparam int RUN_LO  = 3;
  localparam int POS_W   = $clog2(FLEN_HI);
  localparam logic [7:0] B_A1   = 8'hF6;
  localparam logic [7:0] B_A2   = 8'h28;
  localparam logic [7:0] B_FILL = 8'h55;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             byte_en;
  logic [7:0]       rx_byte;
  logic             mode_hi;
  logic             oof, frame_start, ref_8k;
  logic [POS_W-1:0] byte_pos;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  logic s_fs, s_ref;
  logic fs0, ref0, ref_c1, ref_post, oof_hdr;

  always #5 clk = ~clk;

  sonet_frame_aligner #(
    .FLEN_HI (FLEN_HI),
    .FLEN_LO (FLEN_LO),
    .RUN_HI  (RUN_HI),
    .RUN_LO  (RUN_LO)
  ) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_en     (byte_en),
    .rx_byte     (rx_byte),
    .mode_hi     (mode_hi),
    .oof         (oof),
    .frame_start (frame_start),
    .byte_pos    (byte_pos),
    .ref_8k      (ref_8k)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic hi);
    @(negedge clk);
    rst_n   = 1'b0;
    byte_en = 1'b0;
    rx_byte = 8'h00;
    mode_hi = hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_byte = b;
    byte_en = 1'b1;
    #1;
    s_fs  = frame_start;
    s_ref = ref_8k;
    @(posedge clk);
    #1;
    byte_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_fill(input int n);
    for (int i = 0; i < n; i++) send_byte(B_FILL);
  endtask

  // one frame from position 0; bad replaces the last framing byte
  task automatic send_frame(input int run, input int flen, input bit bad);
    for (int i = 0; i < flen; i++) begin
      if (i < run) send_byte(B_A1);
      else if (i < 2 * run) send_byte((bad && i == 2 * run - 1) ? 8'h00 : B_A2);
      else send_byte(B_FILL);
      if (i == 0) begin
        fs0  = s_fs;
        ref0 = s_ref;
      end
      if (i == 2 * run - 1) oof_hdr = oof;
      if (i == 2 * run) ref_c1 = s_ref;
      if (i == 2 * run + 1) ref_post = s_ref;
    end
  endtask

  task automatic test_reset();
    do_reset(1'b1);
    check("R1 oof", int'(oof), 1);
    check("R1 frame_start", int'(frame_start), 0);
    check("R1 ref_8k", int'(ref_8k), 0);
    check("R1 byte_pos", int'(byte_pos), 0);
  endtask

  task automatic test_hi_mode();
    do_reset(1'b1);
    send_fill(5);
    check("R4 count", int'(byte_pos), 5);
    for (int i = 0; i < RUN_HI; i++) send_byte(B_A1);
    for (int i = 0; i < RUN_HI; i++) send_byte(B_A2);
    check("R2 load hi", int'(byte_pos), 2 * RUN_HI);
    check("R6 oof before confirm", int'(oof), 1);
    check("R10 ref while oof", int'(ref_8k), 0);
    send_fill(FLEN_HI - 2 * RUN_HI);
    check("R11 wrap hi", int'(byte_pos), 0);
    send_frame(RUN_HI, FLEN_HI, 1'b0);
    check("R5 start in confirm", int'(fs0), 1);
    check("R10 ref0 while oof", int'(ref0), 0);
    check("R6 confirm clears oof", int'(oof_hdr), 0);
    check("R9 ref at C1", int'(ref_c1), 1);
    check("R9 ref after C1", int'(ref_post), 0);
    check("R4 frame end", int'(byte_pos), 0);
    for (int k = 0; k < 3; k++) begin
      send_frame(RUN_HI, FLEN_HI, 1'b1);
      check("R8 first bad run", int'(oof_hdr), 0);
    end
    send_frame(RUN_HI, FLEN_HI, 1'b0);
    check("R9 ref0 in frame", int'(ref0), 1);
    check("R5 start in frame", int'(fs0), 1);
    for (int k = 0; k < 3; k++) send_frame(RUN_HI, FLEN_HI, 1'b1);
    check("R8 good frame resets count", int'(oof_hdr), 0);
    send_frame(RUN_HI, FLEN_HI, 1'b1);
    check("R7 fourth bad sets oof", int'(oof_hdr), 1);
    send_frame(RUN_HI, FLEN_HI, 1'b0);
    check("R5 no start while searching", int'(fs0), 0);
    check("R10 ref0 after loss", int'(ref0), 0);
    check("R6 oof held until confirm", int'(oof_hdr), 1);
    send_frame(RUN_HI, FLEN_HI, 1'b0);
    check("R6 reacquire", int'(oof_hdr), 0);
  endtask

  task automatic test_lo_mode();
    do_reset(1'b0);
    send_byte(B_FILL); send_byte(B_FILL);
    send_byte(B_A1); send_byte(B_A1);
    send_byte(B_A2); send_byte(B_A2); send_byte(B_A2);
    check("R3 short A1 run", int'(byte_pos), 7);
    send_byte(B_A1); send_byte(B_A1); send_byte(B_A1);
    send_byte(B_A2); send_byte(B_A2); send_byte(B_FILL);
    check("R3 broken A2 run", int'(byte_pos), 13);
    check("R3 oof kept", int'(oof), 1);
    send_byte(B_A1); send_byte(B_A1);
    idle(2);
    check("R4 hold on gap", int'(byte_pos), 15);
    send_byte(B_A1);
    send_byte(B_A2); send_byte(B_A2); send_byte(B_A2);
    check("R2 load lo", int'(byte_pos), 2 * RUN_LO);
    send_fill(FLEN_LO - 2 * RUN_LO);
    check("R11 wrap lo", int'(byte_pos), 0);
    send_frame(RUN_LO, FLEN_LO, 1'b1);
    check("R5 start in confirm lo", int'(fs0), 1);
    check("R6 failed confirm", int'(oof_hdr), 1);
    send_frame(RUN_LO, FLEN_LO, 1'b0);
    check("R6 back to search", int'(fs0), 0);
    send_frame(RUN_LO, FLEN_LO, 1'b0);
    check("R5 start lo", int'(fs0), 1);
    check("R6 confirm lo", int'(oof_hdr), 0);
    check("R9 ref at C1 lo", int'(ref_c1), 1);
    check("R9 ref after C1 lo", int'(ref_post), 0);
  endtask

  initial begin
    rst_n   = 1'b0;
    byte_en = 1'b0;
    rx_byte = 8'h00;
    mode_hi = 1'b1;
    test_reset();
    test_hi_mode();
    test_lo_mode();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end
endmodule